// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block collects the event flags raised by the transmit and receive engines of a DMA Ethernet MAC. It holds them in a 32-bit event status register. It masks them with a 32-bit enable register and reduces each direction to a summary bit. From those summary bits it drives one level-sensitive interrupt line per direction. Receive events occupy the lower 16 bits and transmit events the upper 16 bits. In each half, bit 0 of the half is the derived summary, so the receive summary is bit 0 and the transmit summary is bit 16.

Software clears pending events by writing ones. A halted-flags register records each time the transmit or receive enable level drops. A control word survives a soft reset only in its loopback and operating-mode bits.

Reads are combinational from a separate read address. Writes take effect on the next rising clock edge.

Top module: `mac_irq_aggregator`

## Requirements
- R1: After `rst_n` is released, all four registers read 0 and both interrupt lines are low.
- R2: The register map is: address 0 is event status, 1 is enable, 2 is halted flags, 3 is control. A pulse on `rx_evt[j]` sets status bit j on the next edge, and a pulse on `tx_evt[j]` sets status bit 16+j. Writing address 0 clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R3: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Status bit 16 (transmit summary) is 1 exactly when at least one of these is both pending and enabled at the same position in the enable register: bit 17 (transmit complete), bit 18 (transmit descriptor unavailable), bit 19 (transmit bus error). It is updated on the same edge as the event or write that changes it.
- R5: Status bit 0 (receive summary) is formed the same way from bit 1 (good frame received), bit 2 (receive descriptor unavailable) and bit 3 (receive bus error).
- R6: `irq_tx` equals status bit 16 AND enable bit 16 as they stood one edge earlier. `irq_rx` is formed the same way from bit 0.
- R7: Status bits 4 to 15 and 20 to 31 latch their events but never affect a summary bit. Event pulses at positions 0 and 16 are ignored.
- R8: Writing address 1 loads all 32 enable bits. Both summary bits are recomputed with the new enable value on that same edge.
- R9: In the halted-flags register, bit 1 is set when `tx_en` falls from 1 to 0, and bit 0 is set when `rx_en` falls. Writing 1 to a flag clears it. A fall in the same cycle as the clear keeps the flag set.
- R10: A cycle with `soft_rst` high clears status, enable, halted flags and both interrupt lines on that edge, overriding same-cycle events and writes. The control register keeps only bits 8 (loopback) and 9 (operating mode).
- R11: Writing address 3 stores any 32-bit value, which reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data, combinational |
| tx_evt | input | 16 | Transmit event pulses, status bits 31:16 |
| rx_evt | input | 16 | Receive event pulses, status bits 15:0 |
| tx_en | input | 1 | Transmit enable level |
| rx_en | input | 1 | Receive enable level |
| irq_tx | output | 1 | Transmit interrupt, registered level |
| irq_rx | output | 1 | Receive interrupt, registered level |

## Verification
An engine can raise an event in the same cycle that software writes 1 to clear that bit. Likewise, an enable level can fall in the same cycle that its halted flag is being cleared. The bench forces both collisions in directed steps and expects the set to survive. A long random phase then mixes event pulses, clears, enable writes, level drops and soft resets freely. A behavioural model compares the outputs against those collisions and against soft reset meeting everything else on every clock.

// File: rtl/mac_irqagg_pkg.sv
`timescale 1ns/1ps
package mac_irqagg_pkg;

  typedef enum logic [1:0] {
    SEL_EVENT  = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_HALT   = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  // Status update: write-1-to-clear first, then new events on top (set wins).
  function automatic logic [31:0] status_merge(input logic [31:0] cur,
                                               input logic [31:0] clr,
                                               input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Summary: any source that is pending, enabled and part of the source set.
  function automatic logic summary_of(input logic [31:0] st,
                                      input logic [31:0] en,
                                      input logic [31:0] src);
    return |(st & en & src);
  endfunction

endpackage

// File: rtl/mac_irqagg_half.sv
`timescale 1ns/1ps
module mac_irqagg_half
  import mac_irqagg_pkg::*;
#(
  parameter int unsigned       HALF_W   = 16,
  parameter int unsigned       SUM_IDX  = 0,
  parameter logic [HALF_W-1:0] SRC_MASK = 16'h000E
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [HALF_W-1:0] evt_set,
  input  logic              stat_wr,
  input  logic              en_wr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [HALF_W-1:0] en_next,
  output logic [HALF_W-1:0] stat_view,
  output logic              sum_q
);

  localparam logic [HALF_W-1:0] SUM_BIT = HALF_W'(1) << SUM_IDX;

  logic [HALF_W-1:0] raw_q;
  logic [HALF_W-1:0] raw_d;
  logic [HALF_W-1:0] set_eff;
  logic [HALF_W-1:0] clr_eff;
  logic              sum_d;
  logic              recompute;

  // The summary position is derived only, never latched from an event.
  assign set_eff   = evt_set & ~SUM_BIT;
  assign clr_eff   = stat_wr ? wdata : '0;
  assign raw_d     = HALF_W'(status_merge(32'(raw_q), 32'(clr_eff), 32'(set_eff)));
  assign sum_d     = summary_of(32'(raw_d), 32'(en_next), 32'(SRC_MASK));
  assign recompute = (|evt_set) | stat_wr | en_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      sum_q <= 1'b0;
    end else if (soft_rst) begin
      raw_q <= '0;
      sum_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      if (recompute) sum_q <= sum_d;
    end
  end

  assign stat_view = raw_q | (sum_q ? SUM_BIT : '0);

endmodule

// File: rtl/mac_irqagg_irq_reg.sv
`timescale 1ns/1ps
module mac_irqagg_irq_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic sum_in,
  input  logic sum_en,
  output logic irq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (soft_rst) irq_q <= 1'b0;
    else               irq_q <= sum_in & sum_en;
  end

endmodule

// File: rtl/mac_irqagg_halt.sv
`timescale 1ns/1ps
module mac_irqagg_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic level,
  input  logic clr,
  output logic flag_q
);

  logic level_q;
  logic fell;

  assign fell = level_q & ~level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (soft_rst) flag_q <= 1'b0;
    else if (fell)     flag_q <= 1'b1;
    else if (clr)      flag_q <= 1'b0;
  end

endmodule

// File: rtl/mac_irq_aggregator.sv
`timescale 1ns/1ps
module mac_irq_aggregator
  import mac_irqagg_pkg::*;
#(
  parameter int unsigned         HALF_W    = 16,
  parameter int unsigned         SUM_IDX   = 0,
  parameter logic [HALF_W-1:0]   SRC_MASK  = 16'h000E,
  parameter logic [2*HALF_W-1:0] CTRL_KEEP = 32'h0000_0300
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                reg_wr,
  input  logic [1:0]          reg_waddr,
  input  logic [2*HALF_W-1:0] reg_wdata,
  input  logic [1:0]          reg_raddr,
  output logic [2*HALF_W-1:0] reg_rdata,
  input  logic [HALF_W-1:0]   tx_evt,
  input  logic [HALF_W-1:0]   rx_evt,
  input  logic                tx_en,
  input  logic                rx_en,
  output logic                irq_tx,
  output logic                irq_rx
);

  localparam int unsigned REG_W  = 2 * HALF_W;
  localparam int unsigned NDIR   = 2;
  localparam int unsigned DIR_RX = 0;
  localparam int unsigned DIR_TX = 1;

  logic wr_stat, wr_en, wr_halt, wr_ctrl;

  assign wr_stat = reg_wr && (reg_sel_e'(reg_waddr) == SEL_EVENT);
  assign wr_en   = reg_wr && (reg_sel_e'(reg_waddr) == SEL_ENABLE);
  assign wr_halt = reg_wr && (reg_sel_e'(reg_waddr) == SEL_HALT);
  assign wr_ctrl = reg_wr && (reg_sel_e'(reg_waddr) == SEL_CTRL);

  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] en_d;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] stat_w;

  assign en_d = wr_en ? reg_wdata : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (soft_rst) en_q <= '0;
    else               en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (soft_rst) ctrl_q <= ctrl_q & CTRL_KEEP;
    else if (wr_ctrl)  ctrl_q <= reg_wdata;
  end

  logic [NDIR-1:0][HALF_W-1:0] evt_arr;
  logic [NDIR-1:0][HALF_W-1:0] view_arr;
  logic [NDIR-1:0][HALF_W-1:0] en_next_arr;
  logic [NDIR-1:0][HALF_W-1:0] en_cur_arr;
  logic [NDIR-1:0][HALF_W-1:0] wdata_arr;
  logic [NDIR-1:0]             sum_arr;
  logic [NDIR-1:0]             irq_arr;
  logic [NDIR-1:0]             lvl_arr;
  logic [NDIR-1:0]             hclr_arr;
  logic [NDIR-1:0]             halt_arr;

  assign evt_arr     = {tx_evt, rx_evt};
  assign en_next_arr = en_d;
  assign en_cur_arr  = en_q;
  assign wdata_arr   = reg_wdata;
  assign lvl_arr     = {tx_en, rx_en};
  assign hclr_arr    = wr_halt ? reg_wdata[NDIR-1:0] : '0;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    mac_irqagg_half #(
      .HALF_W  (HALF_W),
      .SUM_IDX (SUM_IDX),
      .SRC_MASK(SRC_MASK)
    ) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .evt_set  (evt_arr[g]),
      .stat_wr  (wr_stat),
      .en_wr    (wr_en),
      .wdata    (wdata_arr[g]),
      .en_next  (en_next_arr[g]),
      .stat_view(view_arr[g]),
      .sum_q    (sum_arr[g])
    );

    mac_irqagg_irq_reg u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .sum_in  (sum_arr[g]),
      .sum_en  (en_cur_arr[g][SUM_IDX]),
      .irq_q   (irq_arr[g])
    );

    mac_irqagg_halt u_halt (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst),
      .level   (lvl_arr[g]),
      .clr     (hclr_arr[g]),
      .flag_q  (halt_arr[g])
    );
  end

  assign stat_w = view_arr;
  assign irq_tx = irq_arr[DIR_TX];
  assign irq_rx = irq_arr[DIR_RX];

  always_comb begin
    unique case (reg_sel_e'(reg_raddr))
      SEL_EVENT:  reg_rdata = stat_w;
      SEL_ENABLE: reg_rdata = en_q;
      SEL_HALT:   reg_rdata = REG_W'(halt_arr);
      SEL_CTRL:   reg_rdata = ctrl_q;
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mac_irq_aggregator_chk.sv
`timescale 1ns/1ps
module mac_irq_aggregator_chk #(
  parameter int unsigned       HALF_W   = 16,
  parameter int unsigned       SUM_IDX  = 0,
  parameter logic [HALF_W-1:0] SRC_MASK = 16'h000E
)(
  input logic                clk,
  input logic                rst_n,
  input logic                soft_rst,
  input logic [HALF_W-1:0]   tx_evt,
  input logic [HALF_W-1:0]   rx_evt,
  input logic                tx_en,
  input logic [2*HALF_W-1:0] stat,
  input logic [2*HALF_W-1:0] en,
  input logic [1:0]          halt,
  input logic                irq_tx,
  input logic                irq_rx
);

  localparam int unsigned TXS = HALF_W + SUM_IDX;
  localparam logic [2*HALF_W-1:0] SUMV =
    {HALF_W'(1) << SUM_IDX, HALF_W'(1) << SUM_IDX};

  logic [2*HALF_W-1:0] evt_all;
  assign evt_all = {tx_evt, rx_evt} & ~SUMV;

  a_r3_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((stat & $past(evt_all)) == $past(evt_all)));

  a_r4_tx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    stat[TXS] == |(stat[2*HALF_W-1:HALF_W] & en[2*HALF_W-1:HALF_W] & SRC_MASK));

  a_r5_rx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    stat[SUM_IDX] == |(stat[HALF_W-1:0] & en[HALF_W-1:0] & SRC_MASK));

  a_r6_tx_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) || (irq_tx == $past(stat[TXS] & en[TXS])));

  a_r6_rx_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) || (irq_rx == $past(stat[SUM_IDX] & en[SUM_IDX])));

  a_r9_tx_halt_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !soft_rst && $fell(tx_en)) |=> halt[1]);

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat == '0 && en == '0 && halt == 2'b00 && !irq_tx && !irq_rx));

endmodule

bind mac_irq_aggregator mac_irq_aggregator_chk #(
  .HALF_W  (HALF_W),
  .SUM_IDX (SUM_IDX),
  .SRC_MASK(SRC_MASK)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .soft_rst(soft_rst),
  .tx_evt  (tx_evt),
  .rx_evt  (rx_evt),
  .tx_en   (tx_en),
  .stat    (stat_w),
  .en      (en_q),
  .halt    (halt_arr),
  .irq_tx  (irq_tx),
  .irq_rx  (irq_rx)
);

// File: tb/tb_mac_irq_aggregator.sv
`timescale 1ns/1ps
module tb_mac_irq_aggregator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [1:0]  reg_raddr = 2'd0;
  logic [31:0] reg_rdata;
  logic [15:0] tx_evt = 16'd0;
  logic [15:0] rx_evt = 16'd0;
  logic        tx_en = 1'b0;
  logic        rx_en = 1'b0;
  logic        irq_tx, irq_rx;

  always #2 clk = ~clk;

  mac_irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .tx_en(tx_en), .rx_en(rx_en),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit running = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  logic [31:0] m_stat, m_en, m_ctrl, ev;
  logic [1:0]  m_halt;
  logic        m_itx, m_irx, m_ptx, m_prx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_ctrl = 0; m_halt = 0;
      m_itx = 0; m_irx = 0; m_ptx = 0; m_prx = 0;
    end else begin
      if (soft_rst) begin
        m_stat = 0; m_en = 0; m_halt = 0; m_itx = 0; m_irx = 0;
        m_ctrl = m_ctrl & 32'h0000_0300;
      end else begin
        m_itx = m_stat[16] && m_en[16];
        m_irx = m_stat[0] && m_en[0];
        ev = {tx_evt, rx_evt};
        for (int i = 0; i < 32; i++) begin
          if (i != 0 && i != 16) begin
            if (ev[i]) m_stat[i] = 1'b1;
            else if (reg_wr && reg_waddr == 2'd0 && reg_wdata[i]) m_stat[i] = 1'b0;
          end
        end
        if (reg_wr && reg_waddr == 2'd1) m_en = reg_wdata;
        if (reg_wr && reg_waddr == 2'd3) m_ctrl = reg_wdata;
        m_stat[16] = 1'b0;
        m_stat[0]  = 1'b0;
        for (int j = 1; j <= 3; j++) begin
          if (m_stat[16+j] && m_en[16+j]) m_stat[16] = 1'b1;
          if (m_stat[j] && m_en[j]) m_stat[0] = 1'b1;
        end
        if (m_ptx && !tx_en) m_halt[1] = 1'b1;
        else if (reg_wr && reg_waddr == 2'd2 && reg_wdata[1]) m_halt[1] = 1'b0;
        if (m_prx && !rx_en) m_halt[0] = 1'b1;
        else if (reg_wr && reg_waddr == 2'd2 && reg_wdata[0]) m_halt[0] = 1'b0;
      end
      m_ptx = tx_en;
      m_prx = rx_en;
    end
  end

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_en;
      2'd2: return {30'd0, m_halt};
      default: return m_ctrl;
    endcase
  endfunction

  // Per-clock comparison against the model, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n && running) begin
      check("R6 irq_tx vs model", {31'd0, irq_tx}, {31'd0, m_itx});
      check("R6 irq_rx vs model", {31'd0, irq_rx}, {31'd0, m_irx});
      case (reg_raddr)
        2'd0: check("R2 status vs model", reg_rdata, model_read(reg_raddr));
        2'd1: check("R8 enable vs model", reg_rdata, model_read(reg_raddr));
        2'd2: check("R9 halted vs model", reg_rdata, model_read(reg_raddr));
        default: check("R11 control vs model", reg_rdata, model_read(reg_raddr));
      endcase
    end
  end

  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  task automatic quiet();
    reg_wr = 0; tx_evt = 0; rx_evt = 0; soft_rst = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_waddr = a; reg_wdata = d;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_raddr = a;
    #0.2;
    check(tag, reg_rdata, exp);
  endtask

  task automatic irq_chk(input logic etx, input logic erx, input string tag);
    check(tag, {30'd0, irq_tx, irq_rx}, {30'd0, etx, erx});
  endtask

  initial begin
    #80000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    running = 1;
    // R1: reset state
    rd_chk(0, 0, "R1 status"); rd_chk(1, 0, "R1 enable");
    rd_chk(2, 0, "R1 halted"); rd_chk(3, 0, "R1 control");
    irq_chk(0, 0, "R1 irqs");

    // R8: enable write
    wr(1, 32'h000F_000F); tick(); quiet();
    rd_chk(1, 32'h000F_000F, "R8 enable load");
    rd_chk(0, 32'h0, "R8 no pending");

    // R5 / R6: receive good frame
    rx_evt = 16'h0002; tick(); quiet();
    rd_chk(0, 32'h0000_0003, "R5 rx summary");
    irq_chk(0, 0, "R6 rx irq lags");
    tick();
    irq_chk(0, 1, "R6 rx irq raised");

    // R4: transmit complete
    tx_evt = 16'h0002; tick(); quiet();
    rd_chk(0, 32'h0003_0003, "R4 tx summary");
    tick();
    irq_chk(1, 1, "R6 tx irq raised");

    // R2: clear all
    wr(0, 32'hFFFF_FFFF); tick(); quiet();
    rd_chk(0, 32'h0, "R2 clear all");
    tick();
    irq_chk(0, 0, "R6 irqs dropped");

    // R7: non-summary events
    wr(1, 32'hFFFF_FFFF); tick(); quiet();
    rx_evt = 16'h0010; tx_evt = 16'h0010; tick(); quiet();
    rd_chk(0, 32'h0010_0010, "R7 other events");
    tick();
    irq_chk(0, 0, "R7 no irq");
    rx_evt = 16'h0001; tx_evt = 16'h0001; tick(); quiet();
    rd_chk(0, 32'h0010_0010, "R7 summary pulse ignored");

    // R2: partial clear
    wr(0, 32'h0000_0010); tick(); quiet();
    rd_chk(0, 32'h0010_0000, "R2 partial clear");

    // R3: set beats clear
    wr(0, 32'h0000_0004); rx_evt = 16'h0004; tick(); quiet();
    rd_chk(0, 32'h0010_0005, "R3 set wins");

    // R8: enable removes source
    wr(1, 32'hFFFF_FFF1); tick(); quiet();
    rd_chk(0, 32'h0010_0004, "R8 summary recomputed");
    wr(1, 32'hFFFF_FFFE); tick(); quiet();
    rd_chk(0, 32'h0010_0005, "R5 summary back");
    tick();
    irq_chk(0, 0, "R6 summary own enable off");

    // R9: halted flags
    tx_en = 1; rx_en = 1; tick(); tick();
    tx_en = 0; tick();
    rd_chk(2, 32'h2, "R9 tx halted");
    rx_en = 0; tick();
    rd_chk(2, 32'h3, "R9 rx halted");
    wr(2, 32'h2); tick(); quiet();
    rd_chk(2, 32'h1, "R9 clear tx flag");
    tx_en = 1; tick();
    tx_en = 0; wr(2, 32'h2); tick(); quiet();
    rd_chk(2, 32'h3, "R9 fall beats clear");

    // R11 / R10: control and soft reset
    wr(3, 32'hFFFF_FFFF); tick(); quiet();
    rd_chk(3, 32'hFFFF_FFFF, "R11 control store");
    tx_evt = 16'h0002; tick(); quiet();
    tick();
    irq_chk(1, 0, "R6 tx irq before soft reset");
    soft_rst = 1; tx_evt = 16'h0008; tick(); quiet();
    rd_chk(0, 32'h0, "R10 status cleared");
    rd_chk(1, 32'h0, "R10 enable cleared");
    rd_chk(2, 32'h0, "R10 halted cleared");
    rd_chk(3, 32'h0000_0300, "R10 control kept bits");
    irq_chk(0, 0, "R10 irqs low");

    // Random mix, judged by the model every clock.
    for (int k = 0; k < 3000; k++) begin
      tick();
      reg_wr    = ($urandom % 3) == 0;
      reg_waddr = 2'($urandom);
      reg_wdata = $urandom;
      reg_raddr = 2'($urandom);
      tx_evt    = 16'($urandom & $urandom & $urandom);
      rx_evt    = 16'($urandom & $urandom & $urandom);
      soft_rst  = ($urandom % 101) == 0;
      if (($urandom % 8) == 0) tx_en = ~tx_en;
      if (($urandom % 8) == 0) rx_en = ~rx_en;
    end
    tick(); quiet();
    tick(); tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule